// File: doc/BRIEF.md
# Command Tag Free-List Allocator

This block manages a fixed pool of command tags for transfers that are in flight. Free tags form a last-in, first-out chain held in on-chip next-pointer storage. Allocating a tag takes it from the head of the chain. Releasing a tag makes it the new head, so the tag freed most recently is the next one handed out. Each tag also owns a payload slot. The issuing side binds a payload word to a tag it has allocated, and the completion side reads that payload back by tag.

A completion that looks up a tag with no bound payload is a protocol error. The block then raises a sticky error flag and stops generating completion interrupts. A cancel-all scan walks every tag in ascending order. For each tag with a valid payload it emits a cancel pulse carrying the tag and returns that tag to the free chain.

The allocation response and the lookup response are combinational from the current state. All state changes take effect at the clock edge where the request is presented.

Top module: `tag_free_list`

## Requirements
- R1: A synchronous active-high reset puts every tag in the free chain in ascending order. Successive allocations after reset return tag 0, then 1, then 2, and so on. The error flag, the scan-busy flag and the cancel pulse are all low after reset.
- R2: The empty marker is all ones over the tag width (9'h1FF at the default of 256 tags). Once every tag has been allocated, `alloc_empty` is 1 and `alloc_tag` shows the empty marker.
- R3: An allocation returns the current head. The head then moves to the next tag in the chain, so following allocations continue along the chain.
- R4: An allocation request made while the chain is empty changes no state. A tag released afterwards is the next tag allocated, and the chain is empty again after that.
- R5: Released tags are reused most-recently-released first. After releasing A and then B, the next two allocations return B and then A.
- R6: Releasing a tag clears its payload to invalid. A lookup of that tag afterwards shows `look_hit` = 0.
- R7: A bind stores a payload word for a tag. A lookup of that tag shows `look_hit` = 1 and the stored word on `look_data`, and pulses `done_irq` in the same cycle.
- R8: A lookup request for a tag without a valid payload sets `proto_err` at the next edge. `proto_err` stays set until reset. While it is set, `done_irq` stays low even for lookups that hit.
- R9: When a release and an allocation arrive in the same cycle, the release is applied first. The allocation returns the released tag, and the head is left unchanged.
- R10: A `scan_start` pulse starts a cancel-all scan, and `scan_busy` stays high for exactly N cycles. The scan visits tags in ascending order. Each tag with a valid payload produces a one-cycle `cancel_valid` pulse carrying its tag on `cancel_tag`, and is released to the chain, so the highest cancelled tag is allocated first afterwards.
- R11: While a scan is running, external allocate, release and bind requests are ignored, and `alloc_empty` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Take a tag from the free chain this cycle |
| alloc_tag | output | TAG_W (9) | Tag granted, or the all-ones empty marker |
| alloc_empty | output | 1 | No tag can be granted this cycle |
| rel_req | input | 1 | Return a tag to the free chain |
| rel_tag | input | IDX_W (8) | Tag being returned |
| bind_req | input | 1 | Store a payload for a tag |
| bind_tag | input | IDX_W (8) | Tag receiving the payload |
| bind_data | input | DATA_W (32) | Payload word |
| look_req | input | 1 | Completion lookup strobe |
| look_tag | input | IDX_W (8) | Tag being looked up |
| look_hit | output | 1 | The looked-up tag holds a valid payload |
| look_data | output | DATA_W (32) | Payload of the looked-up tag |
| done_irq | output | 1 | Completion interrupt for a hitting lookup |
| proto_err | output | 1 | Sticky protocol-error flag |
| scan_start | input | 1 | Begin the cancel-all scan |
| scan_busy | output | 1 | Scan in progress |
| cancel_valid | output | 1 | One-cycle cancel pulse |
| cancel_tag | output | IDX_W (8) | Tag being cancelled |

## Verification
A corrupted next pointer does not show up when it is written. It shows up at the port only when the chain reaches that tag, which can be many allocations later. For this reason the bench drains all N tags and compares every returned value against the expected order. A head that is lost after an empty allocation, or after a simultaneous release and allocation, appears as a wrong `alloc_tag` on the very next allocation. A stale payload valid bit appears as a wrong `look_hit` or `cancel_valid` in the same cycle the tag is probed.

// File: rtl/tag_fl_pkg.sv
package tag_fl_pkg;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    // Tag width: index bits plus one bit that marks the empty value.
    function automatic int tag_bits(input int n_tags);
        return $clog2(n_tags) + 1;
    endfunction

endpackage

// File: rtl/tfl_link.sv
module tfl_link #(
    parameter int N_TAGS = 256,
    parameter int TAG_W  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [TAG_W-2:0] push_idx,
    input  logic             pop_en,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] pop_tag,
    output logic             pop_empty
);
    localparam int               IDX_W = TAG_W - 1;
    localparam logic [TAG_W-1:0] EMPTY = {TAG_W{1'b1}};

    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] next_q [N_TAGS];
    logic [TAG_W-1:0] cand;
    logic             take;

    // A release in the same cycle is seen first by an allocation.
    assign cand      = push_en ? {1'b0, push_idx} : head_q;
    assign pop_empty = cand[TAG_W-1];
    assign pop_tag   = cand;
    assign take      = pop_en & ~cand[TAG_W-1];
    assign head      = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            for (int i = 0; i < N_TAGS; i++) begin
                next_q[i] <= (i == N_TAGS - 1) ? EMPTY : TAG_W'(i + 1);
            end
        end else begin
            if (push_en) begin
                next_q[push_idx] <= head_q;
                head_q           <= {1'b0, push_idx};
            end
            if (take) begin
                if (push_en) begin
                    head_q           <= head_q;
                    next_q[push_idx] <= EMPTY;
                end else begin
                    head_q                    <= next_q[head_q[IDX_W-1:0]];
                    next_q[head_q[IDX_W-1:0]] <= EMPTY;
                end
            end
        end
    end
endmodule

// File: rtl/tfl_payload.sv
module tfl_payload #(
    parameter int N_TAGS = 256,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [DATA_W-1:0] set_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              look_en,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    output logic              scan_hit,
    output logic              err_flag,
    output logic              irq
);
    logic [N_TAGS-1:0] valid_q;
    logic [DATA_W-1:0] data_q [N_TAGS];
    logic              err_q;

    assign look_hit  = valid_q[look_idx];
    assign look_data = data_q[look_idx];
    assign scan_hit  = valid_q[scan_idx];
    assign err_flag  = err_q;
    assign irq       = look_en & valid_q[look_idx] & ~err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (set_en) valid_q[set_idx] <= 1'b1;
            if (clr_en) valid_q[clr_idx] <= 1'b0;
            if (look_en && !valid_q[look_idx]) err_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) data_q[set_idx] <= set_data;
    end
endmodule

// File: rtl/tfl_scan.sv
module tfl_scan
    import tag_fl_pkg::*;
#(
    parameter int N_TAGS = 256,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             push_en,
    output logic             cancel_valid,
    output logic [IDX_W-1:0] cancel_tag
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_TAGS - 1);

    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;

    assign busy    = (state_q == SCAN_RUN);
    assign idx     = idx_q;
    assign push_en = busy & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SCAN_IDLE;
            idx_q        <= '0;
            cancel_valid <= 1'b0;
            cancel_tag   <= '0;
        end else begin
            cancel_valid <= push_en;
            cancel_tag   <= idx_q;
            unique case (state_q)
                SCAN_IDLE: if (start) begin
                    state_q <= SCAN_RUN;
                    idx_q   <= '0;
                end
                SCAN_RUN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST) state_q <= SCAN_IDLE;
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tag_free_list.sv
module tag_free_list
    import tag_fl_pkg::*;
#(
    parameter int N_TAGS = 256,
    parameter int DATA_W = 32,
    localparam int TAG_W = tag_bits(N_TAGS),
    localparam int IDX_W = TAG_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_empty,
    input  logic              rel_req,
    input  logic [IDX_W-1:0]  rel_tag,
    input  logic              bind_req,
    input  logic [IDX_W-1:0]  bind_tag,
    input  logic [DATA_W-1:0] bind_data,
    input  logic              look_req,
    input  logic [IDX_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    output logic              done_irq,
    output logic              proto_err,
    input  logic              scan_start,
    output logic              scan_busy,
    output logic              cancel_valid,
    output logic [IDX_W-1:0]  cancel_tag
);
    localparam logic [TAG_W-1:0] EMPTY = {TAG_W{1'b1}};

    logic             busy;
    logic [IDX_W-1:0] scan_idx;
    logic             scan_hit;
    logic             scan_push;
    logic             eff_push;
    logic [IDX_W-1:0] eff_idx;
    logic [TAG_W-1:0] head;
    logic [TAG_W-1:0] link_tag;
    logic             link_empty;

    // During a scan the scanner owns the release path.
    assign eff_push    = busy ? scan_push : rel_req;
    assign eff_idx     = busy ? scan_idx  : rel_tag;
    assign alloc_empty = busy | link_empty;
    assign alloc_tag   = busy ? EMPTY : link_tag;
    assign scan_busy   = busy;

    tfl_link #(.N_TAGS(N_TAGS), .TAG_W(TAG_W)) u_link (
        .clk      (clk),
        .rst      (rst),
        .push_en  (eff_push),
        .push_idx (eff_idx),
        .pop_en   (alloc_req & ~busy),
        .head     (head),
        .pop_tag  (link_tag),
        .pop_empty(link_empty)
    );

    tfl_payload #(.N_TAGS(N_TAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_payload (
        .clk      (clk),
        .rst      (rst),
        .set_en   (bind_req & ~busy),
        .set_idx  (bind_tag),
        .set_data (bind_data),
        .clr_en   (eff_push),
        .clr_idx  (eff_idx),
        .look_en  (look_req),
        .look_idx (look_tag),
        .scan_idx (scan_idx),
        .look_hit (look_hit),
        .look_data(look_data),
        .scan_hit (scan_hit),
        .err_flag (proto_err),
        .irq      (done_irq)
    );

    tfl_scan #(.N_TAGS(N_TAGS), .IDX_W(IDX_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .start       (scan_start),
        .hit         (scan_hit),
        .busy        (busy),
        .idx         (scan_idx),
        .push_en     (scan_push),
        .cancel_valid(cancel_valid),
        .cancel_tag  (cancel_tag)
    );
endmodule

// File: rtl/tag_free_list_chk.sv
module tag_free_list_chk #(
    parameter int TAG_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_req,
    input logic             alloc_empty,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             rel_req,
    input logic [TAG_W-2:0] rel_tag,
    input logic             busy,
    input logic [TAG_W-1:0] head,
    input logic             proto_err,
    input logic             done_irq,
    input logic             cancel_valid
);
    // R3: the tag just granted is no longer the head
    a_r3_grant_leaves_head: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_empty) |=> (head != $past(alloc_tag)));

    // R4: an allocation on an empty chain leaves the head alone
    a_r4_empty_no_change: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && alloc_empty && !busy && !rel_req) |=> $stable(head));

    // R5: a lone release becomes the head
    a_r5_release_to_head: assert property (@(posedge clk) disable iff (rst)
        (rel_req && !busy && !alloc_req) |=> (head == {1'b0, $past(rel_tag)}));

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R8: no completion interrupt once the error flag is set
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !done_irq);

    // R10: cancel pulses only follow a scan cycle
    a_r10_cancel_in_scan: assert property (@(posedge clk) disable iff (rst)
        cancel_valid |-> $past(busy));
endmodule

bind tag_free_list tag_free_list_chk #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_req   (alloc_req),
    .alloc_empty (alloc_empty),
    .alloc_tag   (alloc_tag),
    .rel_req     (rel_req),
    .rel_tag     (rel_tag),
    .busy        (scan_busy),
    .head        (head),
    .proto_err   (proto_err),
    .done_irq    (done_irq),
    .cancel_valid(cancel_valid)
);

// File: tb/test_tag_free_list.sv
`timescale 1ns/1ps
module test_tag_free_list;
    localparam int N      = 256;
    localparam int TAG_W  = 9;
    localparam int IDX_W  = 8;
    localparam int DATA_W = 32;
    localparam logic [TAG_W-1:0] EMPTY = 9'h1FF;

    // Each vector packs op[19:18], arg[17:9] and expected[8:0].
    // Ops: 0 allocate (expected tag), 1 release, 2 bind, 3 lookup (expected hit).
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 9'd0, 9'd0},   // R1
        {2'd0, 9'd0, 9'd1},   // R1
        {2'd0, 9'd0, 9'd2},   // R1
        {2'd1, 9'd1, 9'd0},
        {2'd0, 9'd0, 9'd1},   // R5
        {2'd2, 9'd2, 9'd0},
        {2'd3, 9'd2, 9'd1},   // R7
        {2'd1, 9'd0, 9'd0},
        {2'd1, 9'd2, 9'd0},
        {2'd0, 9'd0, 9'd2},   // R5
        {2'd0, 9'd0, 9'd0},   // R5
        {2'd0, 9'd0, 9'd3}    // R3
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_req = 1'b0;
    logic [TAG_W-1:0]  alloc_tag;
    logic              alloc_empty;
    logic              rel_req = 1'b0;
    logic [IDX_W-1:0]  rel_tag = '0;
    logic              bind_req = 1'b0;
    logic [IDX_W-1:0]  bind_tag = '0;
    logic [DATA_W-1:0] bind_data = '0;
    logic              look_req = 1'b0;
    logic [IDX_W-1:0]  look_tag = '0;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic              done_irq;
    logic              proto_err;
    logic              scan_start = 1'b0;
    logic              scan_busy;
    logic              cancel_valid;
    logic [IDX_W-1:0]  cancel_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tag_free_list #(.N_TAGS(N), .DATA_W(DATA_W)) i_tag_free_list (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_tag(alloc_tag), .alloc_empty(alloc_empty),
        .rel_req(rel_req), .rel_tag(rel_tag),
        .bind_req(bind_req), .bind_tag(bind_tag), .bind_data(bind_data),
        .look_req(look_req), .look_tag(look_tag),
        .look_hit(look_hit), .look_data(look_data),
        .done_irq(done_irq), .proto_err(proto_err),
        .scan_start(scan_start), .scan_busy(scan_busy),
        .cancel_valid(cancel_valid), .cancel_tag(cancel_tag)
    );

    function automatic logic [DATA_W-1:0] pay(input int t);
        return DATA_W'(t * 7 + 5);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic do_alloc(input logic [TAG_W-1:0] exp, input string req);
        @(negedge clk);
        alloc_req = 1'b1;
        #1 check(alloc_tag == exp, req, alloc_tag, exp);
        @(posedge clk);
        #1 alloc_req = 1'b0;
    endtask

    task automatic do_rel(input int t);
        @(negedge clk);
        rel_req = 1'b1; rel_tag = IDX_W'(t);
        @(posedge clk);
        #1 rel_req = 1'b0;
    endtask

    task automatic do_bind(input int t);
        @(negedge clk);
        bind_req = 1'b1; bind_tag = IDX_W'(t); bind_data = pay(t);
        @(posedge clk);
        #1 bind_req = 1'b0;
    endtask

    task automatic do_look(input int t, input bit exp_hit, input bit exp_irq, input string req);
        @(negedge clk);
        look_req = 1'b1; look_tag = IDX_W'(t);
        #1;
        check(look_hit == exp_hit, req, look_hit, exp_hit);
        if (exp_hit) check(look_data == pay(t), req, look_data, pay(t));
        check(done_irq == exp_irq, req, done_irq, exp_irq);
        @(posedge clk);
        #1 look_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int ncan;
        int cans [4];

        do_reset();
        // R1: reset state
        @(negedge clk);
        #1;
        check(alloc_empty == 1'b0, "R1", alloc_empty, 0);
        check(alloc_tag == 0, "R1", alloc_tag, 0);
        check(proto_err == 1'b0, "R1", proto_err, 0);
        check(scan_busy == 1'b0 && cancel_valid == 1'b0, "R1", scan_busy, 0);

        for (int v = 0; v < NV; v++) begin
            unique case (VEC[v][19:18])
                2'd0: do_alloc(VEC[v][8:0], "R3/R5 table");
                2'd1: do_rel(int'(VEC[v][17:9]));
                2'd2: do_bind(int'(VEC[v][17:9]));
                default: do_look(int'(VEC[v][17:9]), VEC[v][0], VEC[v][0], "R7 table");
            endcase
        end

        // R9: simultaneous release of 1 and allocation; head stays at 4
        @(negedge clk);
        rel_req = 1'b1; rel_tag = 8'd1; alloc_req = 1'b1;
        #1 check(alloc_tag == 9'd1, "R9", alloc_tag, 1);
        @(posedge clk);
        #1 begin rel_req = 1'b0; alloc_req = 1'b0; end
        do_alloc(9'd4, "R9");

        // R6 and R8: release clears the payload; a missing lookup is an error
        do_bind(2);
        do_rel(2);
        do_alloc(9'd2, "R5");
        do_look(2, 1'b0, 1'b0, "R6");
        @(negedge clk);
        #1 check(proto_err == 1'b1, "R8", proto_err, 1);
        do_bind(2);
        do_look(2, 1'b1, 1'b0, "R8");
        @(negedge clk);
        #1 check(proto_err == 1'b1, "R8", proto_err, 1);

        // R1: reset clears the error; drain all tags in order
        do_reset();
        @(negedge clk);
        #1 check(proto_err == 1'b0, "R1", proto_err, 0);
        for (int t = 0; t < N; t++) do_alloc(TAG_W'(t), "R1");
        // R2: chain is empty
        @(negedge clk);
        #1;
        check(alloc_empty == 1'b1, "R2", alloc_empty, 1);
        check(alloc_tag == EMPTY, "R2", alloc_tag, EMPTY);
        // R4: allocating while empty changes nothing
        do_alloc(EMPTY, "R4");
        do_rel(7);
        do_alloc(9'd7, "R4");
        do_alloc(EMPTY, "R4");

        // R10 and R11: cancel-all scan
        do_bind(3);
        do_bind(10);
        do_bind(200);
        @(negedge clk);
        scan_start = 1'b1;
        @(posedge clk);
        #1 scan_start = 1'b0;
        ncan = 0;
        for (int c = 0; c < N + 4; c++) begin
            @(negedge clk);
            #1;
            if (c == 0) check(scan_busy == 1'b1, "R10", scan_busy, 1);
            if (c == N) check(scan_busy == 1'b0, "R10", scan_busy, 0);
            if (c == N - 1) check(scan_busy == 1'b1, "R10", scan_busy, 1);
            if (cancel_valid) begin
                if (ncan < 4) cans[ncan] = int'(cancel_tag);
                ncan++;
            end
            if (c == 2) begin
                check(alloc_empty == 1'b1, "R11", alloc_empty, 1);
                rel_req = 1'b1; rel_tag = 8'd5;
                alloc_req = 1'b1;
                bind_req = 1'b1; bind_tag = 8'd6; bind_data = pay(6);
            end else begin
                rel_req = 1'b0; alloc_req = 1'b0; bind_req = 1'b0;
            end
        end
        check(ncan == 3, "R10", ncan, 3);
        if (ncan == 3) begin
            check(cans[0] == 3, "R10", cans[0], 3);
            check(cans[1] == 10, "R10", cans[1], 10);
            check(cans[2] == 200, "R10", cans[2], 200);
        end
        @(negedge clk);
        look_tag = 8'd6;
        #1 check(look_hit == 1'b0, "R11", look_hit, 0);
        look_tag = 8'd3;
        #1 check(look_hit == 1'b0, "R6", look_hit, 0);
        do_alloc(9'd200, "R10");
        do_alloc(9'd10, "R10");
        do_alloc(9'd3, "R10");
        do_alloc(EMPTY, "R11");

        finish_run();
    end
endmodule